// File: doc/BRIEF.md
# Timer interrupt flag controller

This block holds the interrupt status of three timer/counters in one 8-bit flag register, with a matching 8-bit enable register beside it. Each timer reports its events to the block. An overflow arrives as a strobe. A compare match is found inside the block by comparing the counter value with its compare value. A capture arrives as a pin strobe, or it is derived from the counter reaching TOP when the capture register serves as TOP. The block records each event as a sticky flag. It raises one request line per flag while that flag, its enable bit and the global interrupt enable are all high.

Software clears flags by writing ones over the bus. The interrupt controller clears a single flag by pulsing that flag's acknowledge line when it takes the vector. A hardware event that lands in the same cycle as a clear takes priority over the clear, so no event is lost. The flag and enable registers are read back directly, and reading them has no side effects.

Top module: `tifc_top`

## Requirements
- R1: After reset the flag register, the enable register and every request line are zero.
- R2: A compare flag goes high in the clock cycle after a cycle in which the counter equals its compare value. The compare flags sit at these positions: bit 7 for timer2, bit 4 for timer1 channel A, bit 3 for timer1 channel B and bit 1 for timer0.
- R3: A forced-compare strobe (force_cmp bit 0 timer0, bit 1 timer1 A, bit 2 timer1 B, bit 3 timer2) never sets a flag.
- R4: An overflow strobe sets its flag in the next cycle. The overflow flags sit at bit 6 for timer2, bit 2 for timer1 and bit 0 for timer0.
- R5: The capture flag (bit 5) follows the capture pin strobe while t1_cap_top_mode is 0. While it is 1, the pin is ignored and the flag is set the cycle after t1_count equals t1_cap_reg.
- R6: A flag write clears exactly those flags whose wr_data bit is 1. Bits written as 0 keep their value.
- R7: A pulse on ack[i] clears flag i only.
- R8: When a set event and a clear (a write of one or an acknowledge) hit the same flag in the same cycle, the flag ends up set.
- R9: irq[i] is high exactly when flag i, enable bit i and gie are all 1. It follows those inputs in the same cycle.
- R10: An enable write loads wr_data into the enable register, which is read back on enables in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| t0_count | input | T0_W | Timer0 counter value |
| t0_cmp | input | T0_W | Timer0 compare value |
| t0_ovf | input | 1 | Timer0 wrap strobe |
| t1_count | input | T1_W | Timer1 counter value |
| t1_cmp_a | input | T1_W | Timer1 compare value, channel A |
| t1_cmp_b | input | T1_W | Timer1 compare value, channel B |
| t1_ovf | input | 1 | Timer1 wrap strobe |
| t1_cap_pin | input | 1 | Timer1 capture pin event strobe |
| t1_cap_top_mode | input | 1 | Capture register used as TOP |
| t1_cap_reg | input | T1_W | Timer1 capture register value |
| t2_count | input | T2_W | Timer2 counter value |
| t2_cmp | input | T2_W | Timer2 compare value |
| t2_ovf | input | 1 | Timer2 wrap strobe |
| force_cmp | input | 4 | Forced-compare strobes |
| gie | input | 1 | Global interrupt enable |
| flag_wr | input | 1 | Write-one-to-clear strobe for the flags |
| enable_wr | input | 1 | Load strobe for the enable register |
| wr_data | input | 8 | Bus write data |
| ack | input | 8 | Per-vector acknowledge pulses |
| flags | output | 8 | Flag register readback |
| enables | output | 8 | Enable register readback |
| irq | output | 8 | Per-source interrupt requests |

## Verification
Every flag and enable change is due exactly one clock after the cycle that carries its cause. The irq lines are combinational, so they are due in the same cycle once the flag, enable and gie values are in place. The bench drives all inputs just after a falling edge and holds them across the rising edge. It then compares the flags, the enables and irq at the next falling edge with a model that was advanced once for that edge. A flag that is wrongly late, early or missing is therefore caught in the cycle where it should have appeared.

// File: rtl/tifc_pkg.sv
package tifc_pkg;
  localparam int NFLAG = 8;
  localparam int NCMP  = 4;

  // Bit positions in the flag and enable registers (software-visible layout)
  localparam int B_T0_OVF  = 0;
  localparam int B_T0_CMP  = 1;
  localparam int B_T1_OVF  = 2;
  localparam int B_T1_CMPB = 3;
  localparam int B_T1_CMPA = 4;
  localparam int B_T1_CAP  = 5;
  localparam int B_T2_OVF  = 6;
  localparam int B_T2_CMP  = 7;

  typedef logic [NFLAG-1:0] flag_vec_t;

  localparam flag_vec_t CMP_MASK = flag_vec_t'((1 << B_T0_CMP) | (1 << B_T1_CMPA) |
                                               (1 << B_T1_CMPB) | (1 << B_T2_CMP));

  // Sticky update: set has priority over clear
  function automatic flag_vec_t flag_update(flag_vec_t cur, flag_vec_t set_v, flag_vec_t clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

  // Clear vector from the bus write and the acknowledge lines
  function automatic flag_vec_t clear_vec(logic wr, flag_vec_t data, flag_vec_t ackv);
    return (wr ? data : '0) | ackv;
  endfunction

  // Request gating
  function automatic flag_vec_t req_gate(flag_vec_t f, flag_vec_t en, logic g);
    return f & en & {NFLAG{g}};
  endfunction
endpackage

// File: rtl/tifc_match.sv
module tifc_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] count,
  input  logic [W-1:0] target,
  output logic         hit
);
  assign hit = (count == target);
endmodule

// File: rtl/tifc_event_map.sv
module tifc_event_map
  import tifc_pkg::*;
#(
  parameter int T0_W = 8,
  parameter int T1_W = 16,
  parameter int T2_W = 8
) (
  input  logic [T0_W-1:0] t0_count,
  input  logic [T0_W-1:0] t0_cmp,
  input  logic            t0_ovf,
  input  logic [T1_W-1:0] t1_count,
  input  logic [T1_W-1:0] t1_cmp_a,
  input  logic [T1_W-1:0] t1_cmp_b,
  input  logic            t1_ovf,
  input  logic            t1_cap_pin,
  input  logic            t1_cap_top_mode,
  input  logic [T1_W-1:0] t1_cap_reg,
  input  logic [T2_W-1:0] t2_count,
  input  logic [T2_W-1:0] t2_cmp,
  input  logic            t2_ovf,
  output logic [NCMP-1:0] cmp_hit,
  output logic            top_hit,
  output flag_vec_t       set_vec
);
  // cmp_hit order: 0 timer0, 1 timer1 A, 2 timer1 B, 3 timer2
  tifc_match #(.W(T0_W)) u_m_t0  (.count(t0_count), .target(t0_cmp),     .hit(cmp_hit[0]));
  tifc_match #(.W(T1_W)) u_m_t1a (.count(t1_count), .target(t1_cmp_a),   .hit(cmp_hit[1]));
  tifc_match #(.W(T1_W)) u_m_t1b (.count(t1_count), .target(t1_cmp_b),   .hit(cmp_hit[2]));
  tifc_match #(.W(T2_W)) u_m_t2  (.count(t2_count), .target(t2_cmp),     .hit(cmp_hit[3]));
  tifc_match #(.W(T1_W)) u_m_top (.count(t1_count), .target(t1_cap_reg), .hit(top_hit));

  logic cap_event;
  assign cap_event = t1_cap_top_mode ? top_hit : t1_cap_pin;

  always_comb begin
    set_vec              = '0;
    set_vec[B_T0_OVF]    = t0_ovf;
    set_vec[B_T0_CMP]    = cmp_hit[0];
    set_vec[B_T1_OVF]    = t1_ovf;
    set_vec[B_T1_CMPB]   = cmp_hit[2];
    set_vec[B_T1_CMPA]   = cmp_hit[1];
    set_vec[B_T1_CAP]    = cap_event;
    set_vec[B_T2_OVF]    = t2_ovf;
    set_vec[B_T2_CMP]    = cmp_hit[3];
  end
endmodule

// File: rtl/tifc_flag_reg.sv
module tifc_flag_reg
  import tifc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  flag_vec_t clr_vec,
  output flag_vec_t flags
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= flag_update(flags, set_vec, clr_vec);
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_vec & ~set_vec) != '0) |=> ((flags & $past(clr_vec & ~set_vec)) == '0)); // R6
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0)); // R2
endmodule

// File: rtl/tifc_irq_gate.sv
module tifc_irq_gate
  import tifc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t flags,
  input  flag_vec_t enables,
  input  logic      gie,
  output flag_vec_t irq
);
  assign irq = req_gate(flags, enables, gie);

  AST_GIE_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !gie |-> (irq == '0)); // R9
  AST_REQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    ((irq & ~flags) == '0)); // R9
endmodule

// File: rtl/tifc_top.sv
module tifc_top
  import tifc_pkg::*;
#(
  parameter int T0_W = 8,
  parameter int T1_W = 16,
  parameter int T2_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [T0_W-1:0] t0_count,
  input  logic [T0_W-1:0] t0_cmp,
  input  logic            t0_ovf,
  input  logic [T1_W-1:0] t1_count,
  input  logic [T1_W-1:0] t1_cmp_a,
  input  logic [T1_W-1:0] t1_cmp_b,
  input  logic            t1_ovf,
  input  logic            t1_cap_pin,
  input  logic            t1_cap_top_mode,
  input  logic [T1_W-1:0] t1_cap_reg,
  input  logic [T2_W-1:0] t2_count,
  input  logic [T2_W-1:0] t2_cmp,
  input  logic            t2_ovf,
  input  logic [3:0]      force_cmp,
  input  logic            gie,
  input  logic            flag_wr,
  input  logic            enable_wr,
  input  logic [7:0]      wr_data,
  input  logic [7:0]      ack,
  output logic [7:0]      flags,
  output logic [7:0]      enables,
  output logic [7:0]      irq
);
  logic [NCMP-1:0] cmp_hit;
  logic            top_hit;
  flag_vec_t       set_vec;
  flag_vec_t       clr_vec;
  flag_vec_t       flag_q;
  flag_vec_t       en_q;
  flag_vec_t       irq_w;

  tifc_event_map #(.T0_W(T0_W), .T1_W(T1_W), .T2_W(T2_W)) u_events (
    .t0_count(t0_count), .t0_cmp(t0_cmp), .t0_ovf(t0_ovf),
    .t1_count(t1_count), .t1_cmp_a(t1_cmp_a), .t1_cmp_b(t1_cmp_b), .t1_ovf(t1_ovf),
    .t1_cap_pin(t1_cap_pin), .t1_cap_top_mode(t1_cap_top_mode), .t1_cap_reg(t1_cap_reg),
    .t2_count(t2_count), .t2_cmp(t2_cmp), .t2_ovf(t2_ovf),
    .cmp_hit(cmp_hit), .top_hit(top_hit), .set_vec(set_vec)
  );

  assign clr_vec = clear_vec(flag_wr, wr_data, ack);

  tifc_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec), .flags(flag_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         en_q <= '0;
    else if (enable_wr) en_q <= wr_data;
  end

  tifc_irq_gate u_gate (
    .clk(clk), .rst_n(rst_n), .flags(flag_q), .enables(en_q), .gie(gie), .irq(irq_w)
  );

  assign flags   = flag_q;
  assign enables = en_q;
  assign irq     = irq_w;

  AST_FORCE_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((force_cmp != '0) && (cmp_hit == '0)) |=> ((flags & ~$past(flags) & CMP_MASK) == '0)); // R3
  AST_CAP_PIN_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (t1_cap_top_mode && !top_hit && !$past(flags[B_T1_CAP]) && !flags[B_T1_CAP]) |=> !flags[B_T1_CAP]); // R5
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~set_vec) != '0) |=> ((flags & $past(ack & ~set_vec)) == '0)); // R7
  AST_ENABLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    enable_wr |=> (enables == $past(wr_data))); // R10
endmodule

// File: tb/tifc_top_tb.sv
module tifc_top_tb;
  localparam int T0_W = 8;
  localparam int T1_W = 16;
  localparam int T2_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [T0_W-1:0] t0_count, t0_cmp;
  logic t0_ovf, t1_ovf, t2_ovf, t1_cap_pin, t1_cap_top_mode, gie, flag_wr, enable_wr;
  logic [T1_W-1:0] t1_count, t1_cmp_a, t1_cmp_b, t1_cap_reg;
  logic [T2_W-1:0] t2_count, t2_cmp;
  logic [3:0] force_cmp;
  logic [7:0] wr_data, ack;
  logic [7:0] flags, enables, irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;
  logic [7:0] exp_f, exp_e;

  always #2.5 clk = ~clk;

  tifc_top #(.T0_W(T0_W), .T1_W(T1_W), .T2_W(T2_W)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .t0_count(t0_count), .t0_cmp(t0_cmp), .t0_ovf(t0_ovf),
    .t1_count(t1_count), .t1_cmp_a(t1_cmp_a), .t1_cmp_b(t1_cmp_b), .t1_ovf(t1_ovf),
    .t1_cap_pin(t1_cap_pin), .t1_cap_top_mode(t1_cap_top_mode), .t1_cap_reg(t1_cap_reg),
    .t2_count(t2_count), .t2_cmp(t2_cmp), .t2_ovf(t2_ovf),
    .force_cmp(force_cmp), .gie(gie), .flag_wr(flag_wr), .enable_wr(enable_wr),
    .wr_data(wr_data), .ack(ack), .flags(flags), .enables(enables), .irq(irq)
  );

  // Expected next flags, built bit by bit from the requirement text
  function automatic logic [7:0] next_flags(logic [7:0] cur);
    logic [7:0] s;
    logic [7:0] c;
    s[7] = (t2_count == t2_cmp);
    s[6] = t2_ovf;
    s[5] = t1_cap_top_mode ? (t1_count == t1_cap_reg) : t1_cap_pin;
    s[4] = (t1_count == t1_cmp_a);
    s[3] = (t1_count == t1_cmp_b);
    s[2] = t1_ovf;
    s[1] = (t0_count == t0_cmp);
    s[0] = t0_ovf;
    c = ack;
    if (flag_wr) c = c | wr_data;
    return (cur & ~c) | s;
  endfunction

  function automatic logic [7:0] want_irq(logic [7:0] f, logic [7:0] e, logic g);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = f[i] && e[i] && g;
    return r;
  endfunction

  task automatic idle();
    t0_count = 8'd0;  t0_cmp = 8'd1;  t0_ovf = 0;
    t1_count = 16'd0; t1_cmp_a = 16'd1; t1_cmp_b = 16'd2; t1_ovf = 0;
    t1_cap_pin = 0; t1_cap_top_mode = 0; t1_cap_reg = 16'd3;
    t2_count = 8'd0;  t2_cmp = 8'd1;  t2_ovf = 0;
    force_cmp = 0; flag_wr = 0; enable_wr = 0; wr_data = 0; ack = 0;
  endtask

  // Inputs are already driven after a falling edge; one rising edge, return at the next falling edge
  task automatic tick();
    logic [7:0] nf, ne;
    nf = next_flags(exp_f);
    ne = enable_wr ? wr_data : exp_e;
    @(posedge clk);
    exp_f = nf;
    exp_e = ne;
    @(negedge clk);
  endtask

  task automatic check(string tag);
    logic [7:0] wi;
    wi = want_irq(exp_f, exp_e, gie);
    checks++;
    if (flags !== exp_f || enables !== exp_e || irq !== wi) begin
      errors++;
      $display("FAIL %s: flags=%h enables=%h irq=%h expected flags=%h enables=%h irq=%h",
               tag, flags, enables, irq, exp_f, exp_e, wi);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    gie = 0;
    exp_f = 0; exp_e = 0;
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");

    // R10 enable load
    enable_wr = 1; wr_data = 8'hFF; tick(); idle();
    check("R10 enable write");
    gie = 1;

    // R2 compare matches, one at a time
    t0_count = 8'd9; t0_cmp = 8'd9; tick(); idle();
    check("R2 timer0 compare bit1");
    t1_count = 16'h1234; t1_cmp_a = 16'h1234; tick(); idle();
    check("R2 timer1 A bit4");
    t1_count = 16'h0777; t1_cmp_b = 16'h0777; tick(); idle();
    check("R2 timer1 B bit3");
    t2_count = 8'hFE; t2_cmp = 8'hFE; tick(); idle();
    check("R2 timer2 bit7 and R9 irq");
    flag_wr = 1; wr_data = 8'hFF; tick(); idle();
    check("R6 clear all");

    // R3 forced compare
    force_cmp = 4'hF; tick(); idle();
    check("R3 force no set");

    // R4 overflows
    t0_ovf = 1; tick(); idle(); check("R4 timer0 overflow bit0");
    t1_ovf = 1; t2_ovf = 1; tick(); idle(); check("R4 timer1/2 overflow bits2,6");

    // R5 capture
    t1_cap_pin = 1; tick(); idle(); check("R5 pin sets capture");
    flag_wr = 1; wr_data = 8'h20; tick(); idle(); check("R6 clear capture only");
    t1_cap_top_mode = 1; t1_cap_pin = 1; tick(); idle(); check("R5 pin ignored in top mode");
    t1_cap_top_mode = 1; t1_count = 16'h00FF; t1_cap_reg = 16'h00FF; tick(); idle();
    check("R5 top reached sets capture");

    // R6 write zero keeps
    flag_wr = 1; wr_data = 8'h00; tick(); idle(); check("R6 write zero keeps");
    flag_wr = 1; wr_data = 8'h0F; tick(); idle(); check("R6 write ones clears low nibble");

    // R7 ack only own flag
    ack = 8'h40; tick(); idle(); check("R7 ack bit6 only");

    // R8 set wins
    t0_ovf = 1; flag_wr = 1; wr_data = 8'h01; tick(); idle(); check("R8 set beats write clear");
    t1_ovf = 1; ack = 8'h04; tick(); idle(); check("R8 set beats ack");

    // R9 gie and enable gating
    gie = 0; @(negedge clk); check("R9 gie low");
    gie = 1; enable_wr = 1; wr_data = 8'h05; tick(); idle(); check("R9 partial enables");

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      t0_count = 8'($urandom); t0_cmp = ($urandom_range(0, 3) == 0) ? t0_count : 8'($urandom);
      t1_count = 16'($urandom);
      t1_cmp_a = ($urandom_range(0, 3) == 0) ? t1_count : 16'($urandom);
      t1_cmp_b = ($urandom_range(0, 3) == 0) ? t1_count : 16'($urandom);
      t1_cap_reg = ($urandom_range(0, 3) == 0) ? t1_count : 16'($urandom);
      t2_count = 8'($urandom); t2_cmp = ($urandom_range(0, 3) == 0) ? t2_count : 8'($urandom);
      t0_ovf = ($urandom_range(0, 5) == 0); t1_ovf = ($urandom_range(0, 5) == 0);
      t2_ovf = ($urandom_range(0, 5) == 0);
      t1_cap_pin = ($urandom_range(0, 3) == 0); t1_cap_top_mode = ($urandom_range(0, 1) == 0);
      force_cmp = 4'($urandom);
      flag_wr = ($urandom_range(0, 3) == 0); enable_wr = ($urandom_range(0, 7) == 0);
      wr_data = 8'($urandom);
      ack = ($urandom_range(0, 2) == 0) ? (8'd1 << $urandom_range(0, 7)) : 8'd0;
      gie = ($urandom_range(0, 4) != 0);
      tick();
      check("RND R2 R4 R5 R6 R7 R8 R9 R10");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule